// File: doc/BRIEF.md
# Thresholded Interrupt Request Collector

This block gathers interrupt requests from many sources into a one-bit-per-vector pending register covering 256 vector numbers. Each request arrives as a single-cycle strobe carrying an 8-bit vector number. The bit for that vector is set and stays set until the processor acknowledges it. If a vector is requested again while its bit is still set, the two requests combine into one. Handlers must therefore service all outstanding work for a vector, and must not expect one delivery per request.

The block presents the processor with at most one vector at a time. That vector is the highest-numbered pending vector. It is presented only if its priority class is strictly above a 4-bit task priority threshold that software can write. The priority class is the upper nibble of the vector number. A vector held back by the threshold is not lost. It waits, with no time limit, until software lowers the threshold far enough. The processor acknowledges the presented vector with a single-cycle strobe, and this clears the vector's pending bit.

Top module: `irq_threshold_ctrl`

## Requirements
- R1: After reset, no vector is pending, the threshold is 0, `irq` is low and `irqVector` reads 0.
- R2: A cycle with `reqValid` high sets the pending bit of `reqVector` at that clock edge. If the vector is eligible, `irq` is high from the following cycle with `irqVector` equal to it.
- R3: Requests for a vector that is already pending merge with it. A single acknowledge removes the vector, however many requests arrived.
- R4: The priority class of a vector is bits 7:4 of its number. A pending vector is presented only when its class is strictly greater than the threshold.
- R5: With threshold 15, `irq` stays low whatever is pending. With threshold 0, every vector of class 1 to 15 is deliverable, and class-0 vectors (0x00 to 0x0F) are never delivered.
- R6: A vector blocked by the threshold keeps its pending bit for any number of cycles. It is presented once the threshold drops below its class.
- R7: `ack` while `irq` is high clears the pending bit of the presented `irqVector` at that edge, and the next eligible vector (if any) appears in the following cycle. `ack` while `irq` is low has no effect.
- R8: When several pending vectors are eligible, the one with the highest vector number is presented.
- R9: A request and an acknowledge for the same vector at the same edge leave that vector pending.
- R10: A cycle with `thrWrite` high loads `thrData` into the threshold at that edge. `irq` and `irqVector` reflect the new threshold from the next cycle. `irq` drops if no eligible vector remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| reqVector | input | 8 | Vector number of the request |
| thrWrite | input | 1 | Threshold write strobe |
| thrData | input | 4 | New threshold value |
| ack | input | 1 | Processor acknowledge of the presented vector |
| irq | output | 1 | Interrupt line to the processor |
| irqVector | output | 8 | Presented vector number, 0 when `irq` is low |

## Verification
The bench fills the pending register with vectors of different classes and then steps the threshold through 0, 7, 8, 14 and 15. Each step tells apart a strict comparison from a non-strict one and a class comparison from a full-vector comparison.

Repeated requests for one vector followed by a single acknowledge separate merging from counting. Draining several eligible vectors one acknowledge at a time exposes the delivery order.

An acknowledge issued together with a new request for the same vector checks that the set wins over the clear. An acknowledge issued while `irq` is low checks that it is ignored.

// File: rtl/irqThrPkg.sv
package irqThrPkg;
  localparam int VEC_W   = 8;
  localparam int CLASS_W = 4;
  localparam int NUM_VEC = 1 << VEC_W;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic             setEn;
    logic [VEC_W-1:0] setVec;
    logic             clrEn;
    logic [VEC_W-1:0] clrVec;
    logic             thrEn;
    logic [CLASS_W-1:0] thrVal;
  } ctlStrobes_t;
endpackage

// File: rtl/irqThrControl.sv
module irqThrControl
  import irqThrPkg::*;
(
  input  logic               reqValid,
  input  logic [VEC_W-1:0]   reqVector,
  input  logic               thrWrite,
  input  logic [CLASS_W-1:0] thrData,
  input  logic               ack,
  input  logic               irqOut,
  input  logic [VEC_W-1:0]   irqVecOut,
  output ctlStrobes_t        strobes
);
  always_comb begin
    strobes.setEn  = reqValid;
    strobes.setVec = reqVector;
    // An acknowledge only counts while a vector is being presented
    strobes.clrEn  = ack && irqOut;
    strobes.clrVec = irqVecOut;
    strobes.thrEn  = thrWrite;
    strobes.thrVal = thrData;
  end
endmodule

// File: rtl/irqThrDatapath.sv
module irqThrDatapath
  import irqThrPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  output logic               irqOut,
  output logic [VEC_W-1:0]   irqVecOut
);
  localparam int GRP_W    = VEC_W - CLASS_W;
  localparam int GRP_SIZE = 1 << GRP_W;
  localparam int NUM_GRP  = 1 << CLASS_W;

  logic [NUM_VEC-1:0] pendQ, pendD;
  logic [CLASS_W-1:0] thrQ;

  // Update order: clear first, then set, so a set wins a same-vector clash
  always_comb begin
    pendD = pendQ;
    if (strobes.clrEn) pendD[strobes.clrVec] = 1'b0;
    if (strobes.setEn) pendD[strobes.setVec] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      thrQ  <= '0;
    end else begin
      pendQ <= pendD;
      if (strobes.thrEn) thrQ <= strobes.thrVal;
    end
  end

  // Two-level priority search: highest member within each class, then highest class
  logic [NUM_GRP-1:0] grpAny;
  logic [GRP_W-1:0]   grpTop [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGroup
    logic [GRP_SIZE-1:0] slice;
    assign slice     = pendQ[g*GRP_SIZE +: GRP_SIZE];
    assign grpAny[g] = |slice;
    always_comb begin
      grpTop[g] = '0;
      for (int i = 0; i < GRP_SIZE; i++)
        if (slice[i]) grpTop[g] = GRP_W'(i);
    end
  end

  logic [CLASS_W-1:0] topGrp;
  always_comb begin
    topGrp = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (grpAny[g]) topGrp = CLASS_W'(g);
  end

  // The highest pending vector always sits in the highest class, so only it needs the gate
  logic eligible;
  assign eligible  = (|grpAny) && (topGrp > thrQ);
  assign irqOut    = eligible;
  assign irqVecOut = eligible ? {topGrp, grpTop[topGrp]} : '0;
endmodule

// File: rtl/irq_threshold_ctrl.sv
module irq_threshold_ctrl
  import irqThrPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [VEC_W-1:0]   reqVector,
  input  logic               thrWrite,
  input  logic [CLASS_W-1:0] thrData,
  input  logic               ack,
  output logic               irq,
  output logic [VEC_W-1:0]   irqVector
);
  ctlStrobes_t strobes;

  irqThrControl uCtl (
    .reqValid  (reqValid),
    .reqVector (reqVector),
    .thrWrite  (thrWrite),
    .thrData   (thrData),
    .ack       (ack),
    .irqOut    (irq),
    .irqVecOut (irqVector),
    .strobes   (strobes)
  );

  irqThrDatapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .irqOut    (irq),
    .irqVecOut (irqVector)
  );
endmodule

// File: rtl/irqThrChecker.sv
module irqThrChecker
  import irqThrPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [VEC_W-1:0]   reqVector,
  input logic               thrWrite,
  input logic [CLASS_W-1:0] thrData,
  input logic               ack,
  input logic               irq,
  input logic [VEC_W-1:0]   irqVector,
  input logic [NUM_VEC-1:0] pend,
  input logic [CLASS_W-1:0] thr
);
  localparam logic [NUM_VEC-1:0] ONE = {{(NUM_VEC-1){1'b0}}, 1'b1};

  // R2 / R9: a request always leaves its bit set, even against an acknowledge
  a_r2_req_sets: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> pend[$past(reqVector)]);

  // R4: a presented vector's class is strictly above the threshold
  a_r4_class_gate: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqVector[VEC_W-1 -: CLASS_W] > thr));

  // R5: threshold 15 blocks everything
  a_r5_full_block: assert property (@(posedge clk) disable iff (!rstN)
    (thr == '1) |-> !irq);

  // R6: without an acknowledge no pending bit is lost
  a_r6_no_loss: assert property (@(posedge clk) disable iff (!rstN)
    !ack |=> (($past(pend) & ~pend) == '0));

  // R7: acknowledge clears the presented vector unless re-requested
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irq && !(reqValid && reqVector == irqVector)) |=> !pend[$past(irqVector)]);

  // R8: nothing pending above the presented vector
  a_r8_highest: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((pend >> irqVector) == ONE));

  // R10: threshold written at the edge of the strobe
  a_r10_thr_load: assert property (@(posedge clk) disable iff (!rstN)
    thrWrite |=> (thr == $past(thrData)));
endmodule

bind irq_threshold_ctrl irqThrChecker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqVector (reqVector),
  .thrWrite  (thrWrite),
  .thrData   (thrData),
  .ack       (ack),
  .irq       (irq),
  .irqVector (irqVector),
  .pend      (uDp.pendQ),
  .thr       (uDp.thrQ)
);

// File: tb/tb_irq_threshold_ctrl.sv
module tb_irq_threshold_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqVector = '0;
  logic       thrWrite = 1'b0;
  logic [3:0] thrData = '0;
  logic       ack = 1'b0;
  logic       irq;
  logic [7:0] irqVector;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic       irq;
    logic [7:0] vec;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_threshold_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector),
    .thrWrite(thrWrite), .thrData(thrData), .ack(ack),
    .irq(irq), .irqVector(irqVector)
  );

  // Monitor: compare outputs against queued expectations, away from the rising edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (irq !== e.irq || irqVector !== e.vec) begin
        fails++;
        $display("FAIL %s: irq=%0b vec=%02h expected irq=%0b vec=%02h",
                 e.tag, irq, irqVector, e.irq, e.vec);
      end
    end
  end

  // Driver: apply one cycle of stimulus, then queue the expected post-edge outputs
  task automatic step(input logic rv, input logic [7:0] rvec,
                      input logic tw, input logic [3:0] td, input logic a,
                      input logic eIrq, input logic [7:0] eVec, input string tag);
    reqValid = rv; reqVector = rvec; thrWrite = tw; thrData = td; ack = a;
    @(posedge clk);
    #1;
    reqValid = 1'b0; thrWrite = 1'b0; ack = 1'b0;
    expQ.push_back('{eIrq, eVec, tag});
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (irq !== 1'b0 || irqVector !== 8'h00) begin
          fails++;
          $display("FAIL R1: irq=%0b vec=%02h expected irq=0 vec=00", irq, irqVector);
        end
        rstN = 1'b1;
        @(posedge clk); #1;
        expQ.push_back('{1'b0, 8'h00, "R1 idle after reset"});
        step(1, 8'h35, 0, 0, 0, 1, 8'h35, "R2 request delivered");
        step(1, 8'h35, 0, 0, 0, 1, 8'h35, "R3 duplicate request");
        step(0, 0,     0, 0, 1, 0, 8'h00, "R3 one ack clears merged");
        step(0, 0,     0, 0, 1, 0, 8'h00, "R7 ack while idle ignored");
        step(1, 8'h05, 0, 0, 0, 0, 8'h00, "R5 class 0 never delivered");
        step(1, 8'h80, 0, 0, 0, 1, 8'h80, "R2 class 8 at thr 0");
        step(1, 8'h7F, 0, 0, 0, 1, 8'h80, "R8 higher number wins");
        step(0, 0,     1, 8, 0, 0, 8'h00, "R4 class equal to thr blocked");
        step(0, 0,     1, 7, 0, 1, 8'h80, "R10 lower thr next cycle");
        step(1, 8'hFF, 1, 15, 0, 0, 8'h00, "R5 thr 15 blocks all");
        for (int i = 0; i < 20; i++)
          step(0, 0, 0, 0, 0, 0, 8'h00, "R6 blocked stays quiet");
        step(0, 0,     1, 14, 0, 1, 8'hFF, "R6 blocked vector released");
        step(1, 8'hFF, 0, 0, 1, 1, 8'hFF, "R9 req and ack same vector");
        step(0, 0,     0, 0, 1, 0, 8'h00, "R7 ack clears, rest blocked");
        step(0, 0,     1, 6, 0, 1, 8'h80, "R6 long-blocked 0x80 delivered");
        step(0, 0,     0, 0, 1, 1, 8'h7F, "R8 next in order after ack");
        step(0, 0,     0, 0, 1, 0, 8'h00, "R7 drain leaves class 0");
        step(0, 0,     1, 0, 0, 0, 8'h00, "R5 thr 0 still skips class 0");
        step(1, 8'h10, 0, 0, 0, 1, 8'h10, "R4 class 1 above thr 0");
        step(0, 0,     0, 0, 1, 0, 8'h00, "R7 final ack");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
      end
      begin
        repeat (2000) @(posedge clk);
        if (!done) begin
          checks++;
          fails++;
          $display("FAIL watchdog: run did not complete, expected completion");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule